// File: doc/BRIEF.md
# Shared Mailbox Window with Ownership Handoff

This block is a 256-bit mailbox shared by two agents: a requester and a responder. The mailbox is split into eight 32-bit words, and each agent has its own simple register port to read and write them. Ownership of the whole window is recorded in bit 31 of the last word (word 7). When that bit is 0 the requester owns the window, and when it is 1 the responder owns it. Only the current owner's writes take effect.

The requester fills words 0 to 6 with its message. It then writes the header into word 7. The hardware forces the owner bit of that write to 1, which hands the window to the responder, and the responder sees a one-cycle request-valid pulse. The responder answers by writing word 7. The hardware clears the owner bit of that write, which hands the window back, and the requester sees a one-cycle response-valid pulse.

While the requester's function reset is in progress, both read ports return all ones and requester writes are dropped. The stored contents are kept during that time. The block does not interpret the header. Its bits pass through as written, except for the owner bit.

Top module: `mbx_window`

## Requirements
- R1: After power-on reset all eight words read 0, the owner flag reads 0 (requester owns), and both valid pulses are low.
- R2: While the requester owns the window, a requester write to word 0..6 is stored on the clock edge. From the next cycle the new value can be read from both ports at that address.
- R3: While the requester owns the window and function reset is low, a requester write to word 7 is stored with bit 31 forced to 1. The owner output is high from the next cycle.
- R4: req_valid_o is high for exactly the one cycle after the edge where ownership passes to the responder, and is low otherwise.
- R5: While the responder owns the window, a responder write to any word is stored. A write to word 7 is stored with bit 31 forced to 0, which returns ownership to the requester from the next cycle.
- R6: rsp_valid_o is high for exactly the one cycle after the edge where ownership returns to the requester, and is low otherwise.
- R7: While the responder owns the window, requester writes to any word, including word 7, leave all eight words unchanged.
- R8: While the requester owns the window, responder writes to any word leave all eight words unchanged.
- R9: While fn_reset_i is high, both read ports return 0xFFFFFFFF at every address, and requester writes are ignored. After fn_reset_i drops, the earlier contents read back unchanged.
- R10: Word 7 bits other than 31 are stored exactly as written in both directions. These are type 2:0, version 5:3, direction 7, status 15:8 and reset-request 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| fn_reset_i | input | 1 | Requester function reset in progress |
| rq_wr_en_i | input | 1 | Requester write strobe |
| rq_addr_i | input | 3 | Requester word address |
| rq_wdata_i | input | 32 | Requester write data |
| rq_rdata_o | output | 32 | Requester read data |
| rs_wr_en_i | input | 1 | Responder write strobe |
| rs_addr_i | input | 3 | Responder word address |
| rs_wdata_i | input | 32 | Responder write data |
| rs_rdata_o | output | 32 | Responder read data |
| owner_o | output | 1 | Owner flag, 1 = responder owns |
| req_valid_o | output | 1 | One-cycle pulse to the responder on handoff |
| rsp_valid_o | output | 1 | One-cycle pulse to the requester on return |

## Verification
Directed sequences run a complete handoff round trip. Word 7 is written with bit 31 both set and clear, which shows that the owner bit is forced rather than copied. Writes from the non-owning side are aimed at word 7 and at the payload words, which separates a gate on ownership from a gate on address. Constrained random traffic drives both ports at once with random addresses, data and function-reset phases. This mix exposes any write that slips past the owner check, and any read mask that leaks stored data while function reset is high.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int MBX_DW    = 32;
  localparam int MBX_WORDS = 8;
  localparam int OWN_BIT   = 31;

  typedef logic [MBX_DW-1:0] word_t;

  // Replace the owner bit of a word, keeping every other bit as written.
  function automatic word_t put_owner(word_t w, logic own);
    word_t r;
    r = w;
    r[OWN_BIT] = own;
    return r;
  endfunction

  // Value presented on a read port: all ones while function reset holds.
  function automatic word_t read_view(word_t w, logic masked);
    return masked ? '1 : w;
  endfunction
endpackage

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int WORDS = mbx_pkg::MBX_WORDS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [WORDS-1:0]      wr_sel,
  input  mbx_pkg::word_t        wr_val,
  output mbx_pkg::word_t [WORDS-1:0] win
);
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         win[g] <= '0;
      else if (wr_sel[g]) win[g] <= wr_val;
    end
  end
endmodule

// File: rtl/mbx_own_ctl.sv
module mbx_own_ctl #(
  parameter int WORDS = mbx_pkg::MBX_WORDS,
  localparam int AW = $clog2(WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fn_reset,
  input  logic                 owner,
  input  logic                 rq_we,
  input  logic [AW-1:0]        rq_addr,
  input  mbx_pkg::word_t       rq_wdata,
  input  logic                 rs_we,
  input  logic [AW-1:0]        rs_addr,
  input  mbx_pkg::word_t       rs_wdata,
  output logic [WORDS-1:0]     wr_sel,
  output mbx_pkg::word_t       wr_val,
  output logic                 hand_fwd,
  output logic                 hand_back,
  output logic                 req_pulse,
  output logic                 rsp_pulse
);
  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  logic rq_ok, rs_ok;

  assign rq_ok     = rq_we && !owner && !fn_reset;
  assign rs_ok     = rs_we && owner;
  assign hand_fwd  = rq_ok && (rq_addr == LAST);
  assign hand_back = rs_ok && (rs_addr == LAST);

  always_comb begin
    wr_sel = '0;
    wr_val = '0;
    if (rq_ok) begin
      wr_sel[rq_addr] = 1'b1;
      wr_val = (rq_addr == LAST) ? mbx_pkg::put_owner(rq_wdata, 1'b1) : rq_wdata;
    end else if (rs_ok) begin
      wr_sel[rs_addr] = 1'b1;
      wr_val = (rs_addr == LAST) ? mbx_pkg::put_owner(rs_wdata, 1'b0) : rs_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_pulse <= 1'b0;
      rsp_pulse <= 1'b0;
    end else begin
      req_pulse <= hand_fwd;
      rsp_pulse <= hand_back;
    end
  end
endmodule

// File: rtl/mbx_rd_port.sv
module mbx_rd_port #(
  parameter int WORDS = mbx_pkg::MBX_WORDS,
  localparam int AW = $clog2(WORDS)
) (
  input  mbx_pkg::word_t [WORDS-1:0] win,
  input  logic [AW-1:0]              addr,
  input  logic                       masked,
  output mbx_pkg::word_t             rdata
);
  assign rdata = mbx_pkg::read_view(win[addr], masked);
endmodule

// File: rtl/mbx_window.sv
module mbx_window #(
  parameter int WORDS = mbx_pkg::MBX_WORDS,
  localparam int AW = $clog2(WORDS),
  localparam int DW = mbx_pkg::MBX_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fn_reset_i,
  input  logic          rq_wr_en_i,
  input  logic [AW-1:0] rq_addr_i,
  input  logic [DW-1:0] rq_wdata_i,
  output logic [DW-1:0] rq_rdata_o,
  input  logic          rs_wr_en_i,
  input  logic [AW-1:0] rs_addr_i,
  input  logic [DW-1:0] rs_wdata_i,
  output logic [DW-1:0] rs_rdata_o,
  output logic          owner_o,
  output logic          req_valid_o,
  output logic          rsp_valid_o
);
  mbx_pkg::word_t [WORDS-1:0] win;
  logic [WORDS-1:0]           wr_sel;
  mbx_pkg::word_t             wr_val;
  logic                       hand_fwd, hand_back;
  logic [WORDS*DW-1:0]        win_flat;

  assign owner_o  = win[WORDS-1][mbx_pkg::OWN_BIT];
  assign win_flat = win;

  mbx_own_ctl #(.WORDS(WORDS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .fn_reset(fn_reset_i), .owner(owner_o),
    .rq_we(rq_wr_en_i), .rq_addr(rq_addr_i), .rq_wdata(rq_wdata_i),
    .rs_we(rs_wr_en_i), .rs_addr(rs_addr_i), .rs_wdata(rs_wdata_i),
    .wr_sel(wr_sel), .wr_val(wr_val), .hand_fwd(hand_fwd), .hand_back(hand_back),
    .req_pulse(req_valid_o), .rsp_pulse(rsp_valid_o)
  );

  mbx_store #(.WORDS(WORDS)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wr_val(wr_val), .win(win)
  );

  mbx_rd_port #(.WORDS(WORDS)) u_rd_rq (
    .win(win), .addr(rq_addr_i), .masked(fn_reset_i), .rdata(rq_rdata_o)
  );

  mbx_rd_port #(.WORDS(WORDS)) u_rd_rs (
    .win(win), .addr(rs_addr_i), .masked(fn_reset_i), .rdata(rs_rdata_o)
  );
endmodule

// File: rtl/mbx_window_chk.sv
module mbx_window_chk #(
  parameter int WORDS = 8,
  parameter int AW = 3,
  parameter int DW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fn_reset_i,
  input logic              rq_wr_en_i,
  input logic [AW-1:0]     rq_addr_i,
  input logic              rs_wr_en_i,
  input logic [AW-1:0]     rs_addr_i,
  input logic              owner_o,
  input logic              req_valid_o,
  input logic              rsp_valid_o,
  input logic [DW-1:0]     rq_rdata_o,
  input logic [DW-1:0]     rs_rdata_o,
  input logic [WORDS*DW-1:0] win_flat
);
  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  // R3
  handoff_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_wr_en_i && rq_addr_i == LAST && !owner_o && !fn_reset_i) |=> owner_o);

  // R4
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (owner_o && !$past(owner_o)));

  // R5
  handoff_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_wr_en_i && rs_addr_i == LAST && owner_o) |=> !owner_o);

  // R6
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> (!owner_o && $past(owner_o)));

  // R7
  rq_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_o && !rs_wr_en_i) |=> $stable(win_flat));

  // R8
  rs_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!owner_o && (!rq_wr_en_i || fn_reset_i)) |=> $stable(win_flat));

  // R9
  reset_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fn_reset_i |-> (rq_rdata_o == '1 && rs_rdata_o == '1));
endmodule

bind mbx_window mbx_window_chk #(.WORDS(WORDS), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fn_reset_i(fn_reset_i),
  .rq_wr_en_i(rq_wr_en_i), .rq_addr_i(rq_addr_i),
  .rs_wr_en_i(rs_wr_en_i), .rs_addr_i(rs_addr_i),
  .owner_o(owner_o), .req_valid_o(req_valid_o), .rsp_valid_o(rsp_valid_o),
  .rq_rdata_o(rq_rdata_o), .rs_rdata_o(rs_rdata_o), .win_flat(win_flat)
);

// File: tb/mbx_window_tb.sv
module mbx_window_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        fn_reset_i = 0;
  logic        rq_wr_en_i = 0, rs_wr_en_i = 0;
  logic [2:0]  rq_addr_i = 0, rs_addr_i = 0;
  logic [31:0] rq_wdata_i = 0, rs_wdata_i = 0;
  logic [31:0] rq_rdata_o, rs_rdata_o;
  logic        owner_o, req_valid_o, rsp_valid_o;

  int tests = 0, fails = 0;
  logic [31:0] model [8];
  bit exp_req, exp_rsp;

  always #10 clk = ~clk;

  mbx_window u_dut (.*);

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic bit m_owner();
    return model[7][31];
  endfunction

  function automatic logic [31:0] with_own(logic [31:0] d, bit o);
    return {o, d[30:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_both(string req, int a);
    logic [31:0] e;
    rq_addr_i = 3'(a); rs_addr_i = 3'(7 - a);
    #1;
    e = fn_reset_i ? 32'hFFFF_FFFF : model[a];
    chk(req, rq_rdata_o, e);
    e = fn_reset_i ? 32'hFFFF_FFFF : model[7 - a];
    chk(req, rs_rdata_o, e);
  endtask

  // Drive at a falling edge, commit at the rising edge, check at the next falling edge.
  task automatic step(bit rqw, int ra, logic [31:0] rd,
                      bit rsw, int sa, logic [31:0] sd, bit fr, string req);
    bit own;
    rq_wr_en_i = rqw; rq_addr_i = 3'(ra); rq_wdata_i = rd;
    rs_wr_en_i = rsw; rs_addr_i = 3'(sa); rs_wdata_i = sd;
    fn_reset_i = fr;
    @(posedge clk);
    own = m_owner();
    exp_req = 0; exp_rsp = 0;
    if (rqw && !own && !fr) begin
      model[ra] = (ra == 7) ? with_own(rd, 1) : rd;
      exp_req = (ra == 7);
    end else if (rsw && own) begin
      model[sa] = (sa == 7) ? with_own(sd, 0) : sd;
      exp_rsp = (sa == 7);
    end
    @(negedge clk);
    rq_wr_en_i = 0; rs_wr_en_i = 0;
    chk({req, "/R4"}, 32'(req_valid_o), 32'(exp_req));
    chk({req, "/R6"}, 32'(rsp_valid_o), 32'(exp_rsp));
    chk({req, "/owner"}, 32'(owner_o), 32'(m_owner()));
    read_both(req, (ra == 7 || sa == 7) ? 7 : ra);
  endtask

  task automatic idle(string req);
    step(0, 0, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    void'($urandom(32'd1234));
    foreach (model[i]) model[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) read_both("R1", a);
    chk("R1 owner", 32'(owner_o), 0);
    chk("R1 pulses", 32'({req_valid_o, rsp_valid_o}), 0);

    // R2 payload writes
    step(1, 0, 32'hA5A5_0001, 0, 0, 0, 0, "R2");
    step(1, 6, 32'h1234_5678, 0, 0, 0, 0, "R2");
    // R8 responder ignored while requester owns
    step(0, 0, 0, 1, 3, 32'hDEAD_BEEF, 0, "R8");
    step(0, 0, 0, 1, 7, 32'hFFFF_FFFF, 0, "R8");
    // R3 + R10 header with bit31 clear: forced to 1
    step(1, 7, 32'h0100_AB8A, 0, 0, 0, 0, "R3 R10");
    idle("R4 single cycle");
    // R7 requester blocked, payload and last word
    step(1, 2, 32'h5555_5555, 0, 0, 0, 0, "R7");
    step(1, 7, 32'h0000_0001, 0, 0, 0, 0, "R7");
    // R5 responder payload then header with bit31 set: forced to 0
    step(0, 0, 0, 1, 4, 32'hCAFE_0004, 0, "R5");
    step(0, 0, 0, 1, 7, 32'h8000_0389, 0, "R5 R10");
    idle("R6 single cycle");
    // R9 function reset: masked reads, requester write dropped
    step(1, 0, 32'h0BAD_0BAD, 0, 0, 0, 1, "R9");
    for (int a = 0; a < 8; a++) read_both("R9", a);
    fn_reset_i = 0;
    for (int a = 0; a < 8; a++) read_both("R9 restore", a);

    // Random traffic
    for (int n = 0; n < 600; n++) begin
      bit fr = ($urandom % 8) == 0;
      step(($urandom % 3) != 0, int'($urandom % 8), $urandom,
           ($urandom % 3) != 0, int'($urandom % 8), $urandom, fr, "R2-rand");
      fn_reset_i = 0;
      read_both("R10 rand", int'($urandom % 8));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule